// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block connects a simple host request port to one byte-wide Extended Data Out DRAM. Each host address is split into a row part and a column part. These are driven onto the shared multiplexed address pins: the row just before the row strobe goes low, and the column just before the column strobe goes low. Every strobe interval is given as a time in picoseconds and turned into a whole number of clock cycles at elaboration, rounding up.

While a row is open, requests to the same row are served with further column strobe pulses and no new row activation. A request to a different row closes the row first. So does a pending refresh request from an outside scheduler. A page burst also ends before the row strobe has been low for longer than the allowed maximum. Writes use early-write timing, so the memory never drives the data pins during a write. Read data is taken while the column strobe is still low, and each read returns exactly one valid pulse.

Top module: `edo_dram_ctrl`

## Requirements
- R1: After reset all four strobes (rasN, casN, weN, oeN) are high, dqOe and hostRvalid are low, and hostReady is high while refReq is low.
- R2: The upper ROW_W bits of hostAddr are the row and the lower COL_W bits are the column. The row is on dramAddr when rasN falls, and the column is on dramAddr when casN falls.
- R3: Every accepted read returns the byte stored at its address, with exactly one hostRvalid pulse per read, in request order.
- R4: In a write, weN is already low and dqOe already high before casN falls. weN does not change while casN is low, and oeN stays high during a write.
- R5: Same-row requests accepted while the row is open are served without raising rasN, so a burst to one row causes one rasN fall.
- R6: A request to a different row raises rasN and opens the new row with a fresh rasN fall.
- R7: rasN is never low for more than RASMAX_CYC consecutive cycles, where RASMAX_CYC = ceil(RASMAX_PS/CLK_PS). A longer same-row burst is split into several activations.
- R8: rasN stays high for at least RP_CYC = ceil(RP_PS/CLK_PS) cycles before it falls again.
- R9: rasN is low for at least RCD_CYC cycles before the first casN fall of an activation. casN is low for at least CAS_CYC cycles each pulse. casN is high for at least CP_CYC cycles between pulses in a page. casN is never low while rasN is high. Each count is the ceiling of its time over CLK_PS.
- R10: While refReq is high no host request is accepted and the open row is closed. refAck is high only when rasN and casN are both high, and once refReq drops the held request opens its row again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Host request valid |
| hostReady | output | 1 | Request accepted when high together with hostReq |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostAddr | input | ROW_W+COL_W | Byte address, row in the upper bits |
| hostWdata | input | DATA_W | Write byte |
| hostRdata | output | DATA_W | Read byte, valid with hostRvalid |
| hostRvalid | output | 1 | One-cycle pulse per completed read |
| refReq | input | 1 | Refresh scheduler asks for the memory |
| refAck | output | 1 | Row closed and precharged; scheduler may proceed |
| dramAddr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| oeN | output | 1 | Output enable, active low |
| dqOut | output | DATA_W | Write data toward the memory |
| dqOe | output | 1 | Enables the dqOut driver |
| dqIn | input | DATA_W | Read data from the memory |

## Verification
If the open-row register is stale, a later same-row or cross-row request shows it at the pins. Either rasN does not rise when it should, or the bench memory model latches the wrong row at the next rasN fall. Both show up within one page step, and the read that follows returns the wrong byte. A wrong count in the strobe sequencer shows at once as a low or high run shorter than its cycle minimum, or a rasN low run longer than the maximum. A wrong read/write flag shows as a byte written through oeN, or weN moving while casN is low. A missed or extra capture shows as a hostRvalid pulse with no matching read in the queue, or a read still waiting when the run drains.

// File: rtl/edo_pkg.sv
`timescale 1ns/1ps
package edo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROWSET,
    ST_RCD,
    ST_COLSET,
    ST_CASLO,
    ST_CASHI,
    ST_PRECH
  } edoState_t;

  // strobe bundle from sequencer to datapath
  typedef struct packed {
    logic take;
    logic selCol;
    logic rasLow;
    logic casLow;
    logic weLow;
    logic oeLow;
    logic drive;
    logic capture;
  } edoCtl_t;

  // time in ps to whole cycles, rounded up, at least one
  function automatic int psToCyc(input int ps, input int clkPs);
    int c;
    c = (ps + clkPs - 1) / clkPs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/edo_ctrl_seq.sv
`timescale 1ns/1ps
module edo_ctrl_seq
  import edo_pkg::*;
#(
  parameter int RCD_CYC    = 4,
  parameter int RP_CYC     = 6,
  parameter int CAS_CYC    = 2,
  parameter int CP_CYC     = 2,
  parameter int RASMAX_CYC = 40000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    hostReq,
  input  logic    hostWe,
  input  logic    rowHit,
  input  logic    refReq,
  output logic    hostReady,
  output logic    refAck,
  output edoCtl_t ctl
);

  localparam int MAX_A   = (RCD_CYC > RP_CYC) ? RCD_CYC : RP_CYC;
  localparam int MAX_B   = (CAS_CYC > CP_CYC) ? CAS_CYC : CP_CYC;
  localparam int MAX_CNT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam int TMR_W   = $clog2(RASMAX_CYC + 1);
  localparam int STEP_CYC = 1 + CAS_CYC + CP_CYC;

  edoState_t state, nextState;
  logic [CNT_W-1:0] cnt, cntLim;
  logic [TMR_W-1:0] rasTmr;
  logic [31:0]      tmrExt;
  logic             opWe;
  logic             cntLast, inPage, rasOpen, pageOk, idleTake, pageTake, take;

  always_comb begin
    inPage  = (state == ST_COLSET) || (state == ST_CASLO) || (state == ST_CASHI);
    rasOpen = inPage || (state == ST_RCD);
    case (state)
      ST_RCD:   cntLim = CNT_W'(RCD_CYC - 1);
      ST_CASLO: cntLim = CNT_W'(CAS_CYC - 1);
      ST_CASHI: cntLim = CNT_W'(CP_CYC - 1);
      ST_PRECH: cntLim = CNT_W'(RP_CYC - 1);
      default:  cntLim = '0;
    endcase
    cntLast = (cnt == cntLim);
    tmrExt  = 32'(rasTmr);
    // another page step must still end inside the row-open limit
    pageOk  = (tmrExt + 32'(STEP_CYC + 1)) <= 32'(RASMAX_CYC);
    idleTake = (state == ST_IDLE) && !refReq;
    pageTake = (state == ST_CASHI) && cntLast && !refReq && rowHit && pageOk;
    hostReady = idleTake || pageTake;
    take      = hostReady && hostReq;
    refAck    = (state == ST_IDLE) && refReq;
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:   if (take) nextState = ST_ROWSET;
      ST_ROWSET: nextState = ST_RCD;
      ST_RCD:    if (cntLast) nextState = ST_COLSET;
      ST_COLSET: nextState = ST_CASLO;
      ST_CASLO:  if (cntLast) nextState = ST_CASHI;
      ST_CASHI:  if (cntLast) nextState = take ? ST_COLSET : ST_PRECH;
      ST_PRECH:  if (cntLast) nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      rasTmr <= '0;
      opWe   <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState != state || state == ST_IDLE) cnt <= '0;
      else                                        cnt <= cnt + 1'b1;
      if (state == ST_ROWSET) rasTmr <= '0;
      else if (rasOpen)       rasTmr <= rasTmr + 1'b1;
      if (take) opWe <= hostWe;
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.take    = take;
    ctl.selCol  = inPage;
    ctl.rasLow  = rasOpen;
    ctl.casLow  = (state == ST_CASLO);
    ctl.weLow   = inPage && opWe;
    ctl.drive   = inPage && opWe;
    ctl.oeLow   = inPage && !opWe;
    ctl.capture = (state == ST_CASHI) && (cnt == '0) && !opWe;
  end

endmodule

// File: rtl/edo_datapath.sv
`timescale 1ns/1ps
module edo_datapath
  import edo_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  edoCtl_t                ctl,
  input  logic [ROW_W+COL_W-1:0] hostAddr,
  input  logic [DATA_W-1:0]      hostWdata,
  input  logic [DATA_W-1:0]      dqIn,
  output logic                   rowHit,
  output logic [DATA_W-1:0]      hostRdata,
  output logic                   hostRvalid,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dramAddr,
  output logic                   rasN,
  output logic                   casN,
  output logic                   weN,
  output logic                   oeN,
  output logic [DATA_W-1:0]      dqOut,
  output logic                   dqOe
);

  localparam int AW    = ROW_W + COL_W;
  localparam int PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic [ROW_W-1:0]  rowReg;
  logic [COL_W-1:0]  colReg;
  logic [DATA_W-1:0] wdReg;

  assign rowHit = (hostAddr[AW-1:COL_W] == rowReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowReg <= '0;
      colReg <= '0;
      wdReg  <= '0;
    end else if (ctl.take) begin
      rowReg <= hostAddr[AW-1:COL_W];
      colReg <= hostAddr[COL_W-1:0];
      wdReg  <= hostWdata;
    end
  end

  // registered pin stage: every strobe leaves from a flop
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dramAddr   <= '0;
      rasN       <= 1'b1;
      casN       <= 1'b1;
      weN        <= 1'b1;
      oeN        <= 1'b1;
      dqOut      <= '0;
      dqOe       <= 1'b0;
      hostRdata  <= '0;
      hostRvalid <= 1'b0;
    end else begin
      dramAddr   <= ctl.selCol ? PIN_W'(colReg) : PIN_W'(rowReg);
      rasN       <= !ctl.rasLow;
      casN       <= !ctl.casLow;
      weN        <= !ctl.weLow;
      oeN        <= !ctl.oeLow;
      dqOe       <= ctl.drive;
      if (ctl.drive) dqOut <= wdReg;
      hostRvalid <= ctl.capture;
      if (ctl.capture) hostRdata <= dqIn;
    end
  end

endmodule

// File: rtl/edo_dram_ctrl.sv
`timescale 1ns/1ps
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int DATA_W    = 8,
  parameter int CLK_PS    = 5000,
  parameter int RCD_PS    = 20000,
  parameter int RP_PS     = 30000,
  parameter int CAS_PS    = 8000,
  parameter int CP_PS     = 8000,
  parameter int RASMAX_PS = 200000000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   hostReq,
  output logic                   hostReady,
  input  logic                   hostWe,
  input  logic [ROW_W+COL_W-1:0] hostAddr,
  input  logic [DATA_W-1:0]      hostWdata,
  output logic [DATA_W-1:0]      hostRdata,
  output logic                   hostRvalid,
  input  logic                   refReq,
  output logic                   refAck,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dramAddr,
  output logic                   rasN,
  output logic                   casN,
  output logic                   weN,
  output logic                   oeN,
  output logic [DATA_W-1:0]      dqOut,
  output logic                   dqOe,
  input  logic [DATA_W-1:0]      dqIn
);

  localparam int RCD_CYC    = psToCyc(RCD_PS, CLK_PS);
  localparam int RP_CYC     = psToCyc(RP_PS, CLK_PS);
  localparam int CAS_CYC    = psToCyc(CAS_PS, CLK_PS);
  localparam int CP_CYC     = psToCyc(CP_PS, CLK_PS);
  localparam int RASMAX_CYC = psToCyc(RASMAX_PS, CLK_PS);

  edoCtl_t ctl;
  logic    rowHit;

  edo_ctrl_seq #(
    .RCD_CYC(RCD_CYC), .RP_CYC(RP_CYC), .CAS_CYC(CAS_CYC),
    .CP_CYC(CP_CYC), .RASMAX_CYC(RASMAX_CYC)
  ) seqInst (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWe(hostWe),
    .rowHit(rowHit), .refReq(refReq), .hostReady(hostReady),
    .refAck(refAck), .ctl(ctl)
  );

  edo_datapath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)
  ) dpInst (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .dqIn(dqIn), .rowHit(rowHit),
    .hostRdata(hostRdata), .hostRvalid(hostRvalid), .dramAddr(dramAddr),
    .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .dqOut(dqOut), .dqOe(dqOe)
  );

endmodule

// File: rtl/edo_dram_chk.sv
`timescale 1ns/1ps
module edo_dram_chk #(
  parameter int RP_CYC     = 6,
  parameter int RASMAX_CYC = 40000
) (
  input logic clk,
  input logic rstN,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic oeN,
  input logic dqOe,
  input logic hostRvalid,
  input logic hostReady,
  input logic refAck
);

  logic [31:0] lowRun, highRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowRun  <= '0;
      highRun <= 32'(RP_CYC);
    end else if (rasN) begin
      lowRun <= '0;
      if (highRun < 32'(RP_CYC)) highRun <= highRun + 1;
    end else begin
      lowRun  <= lowRun + 1;
      highRun <= '0;
    end
  end

  // R7
  ras_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> lowRun < 32'(RASMAX_CYC));

  // R8
  precharge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> highRun >= 32'(RP_CYC));

  // R9
  cas_in_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> !rasN);

  // R9
  ras_fall_cas_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> casN);

  // R4
  early_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(casN) && !weN) |-> ($past(!weN) && dqOe && oeN));

  // R4
  we_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!casN && $past(!casN)) |-> $stable(weN));

  // R3
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostRvalid |=> !hostRvalid);

  // R10
  ref_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    refAck |-> (rasN && casN && !hostReady));

endmodule

bind edo_dram_ctrl edo_dram_chk #(
  .RP_CYC(RP_CYC), .RASMAX_CYC(RASMAX_CYC)
) chkInst (
  .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN),
  .oeN(oeN), .dqOe(dqOe), .hostRvalid(hostRvalid),
  .hostReady(hostReady), .refAck(refAck)
);

// File: tb/edo_dram_ctrl_test.sv
`timescale 1ns/1ps
module edo_dram_ctrl_test;

  localparam int ROW_W = 12, COL_W = 9, DW = 8, AW = ROW_W + COL_W, PIN_W = 12;
  localparam int CLK_PS = 5000, RCD_PS = 20000, RP_PS = 30000;
  localparam int CAS_PS = 8000, CP_PS = 8000, RASMAX_PS = 300000;
  localparam int RCD_CYC    = (RCD_PS + CLK_PS - 1) / CLK_PS;
  localparam int RP_CYC     = (RP_PS + CLK_PS - 1) / CLK_PS;
  localparam int CAS_CYC    = (CAS_PS + CLK_PS - 1) / CLK_PS;
  localparam int CP_CYC     = (CP_PS + CLK_PS - 1) / CLK_PS;
  localparam int RASMAX_CYC = (RASMAX_PS + CLK_PS - 1) / CLK_PS;

  logic clk = 0, rstN = 0;
  logic hostReq = 0, hostWe = 0, refReq = 0;
  logic [AW-1:0] hostAddr = '0;
  logic [DW-1:0] hostWdata = '0;
  logic hostReady, hostRvalid, refAck;
  logic [DW-1:0] hostRdata, dqOut;
  logic [DW-1:0] dqIn = '0;
  logic [PIN_W-1:0] dramAddr;
  logic rasN, casN, weN, oeN, dqOe;

  int compared = 0, mismatched = 0, cycles = 0;
  bit rstDone = 0;

  edo_dram_ctrl #(.RASMAX_PS(RASMAX_PS)) uut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostReady(hostReady),
    .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostRvalid(hostRvalid), .refReq(refReq),
    .refAck(refAck), .dramAddr(dramAddr), .rasN(rasN), .casN(casN),
    .weN(weN), .oeN(oeN), .dqOut(dqOut), .dqOe(dqOe), .dqIn(dqIn)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] initVal(input int a);
    return 8'((a * 7 + (a >> 9)) ^ 8'hA5);
  endfunction

  // behavioural memory on the pins
  logic [7:0] mem [int];
  logic [ROW_W-1:0] curRow = '0;
  always @(negedge rasN) curRow = dramAddr[ROW_W-1:0];
  always @(negedge casN) begin
    int a;
    a = int'({curRow, dramAddr[COL_W-1:0]});
    if (!weN) begin
      chk(dqOe, "R4", "data not driven at write strobe", int'(dqOe), 1);
      mem[a] = dqOut;
    end else begin
      dqIn <= mem.exists(a) ? mem[a] : initVal(a);
    end
  end
  always @(posedge rasN) dqIn <= 'x;
  always @(posedge oeN) dqIn <= 'x;

  // host-side reference
  logic [7:0] refMem [int];
  logic [7:0] expQ [$];
  int accRow = 0, accCol = 0;

  task automatic access(input bit we, input int row, input int col, input logic [7:0] d);
    int a;
    @(negedge clk);
    hostReq = 1; hostWe = we; hostWdata = d;
    hostAddr = {row[ROW_W-1:0], col[COL_W-1:0]};
    #1;
    while (!hostReady) begin @(negedge clk); #1; end
    a = (row << COL_W) | col;
    if (we) refMem[a] = d;
    else expQ.push_back(refMem.exists(a) ? refMem[a] : initVal(a));
    accRow = row; accCol = col;
    @(posedge clk); #1;
    hostReq = 0;
  endtask

  // pin monitor and result compare, every clock
  bit prevRas = 1, prevCas = 1, prevWe = 1, firstCas = 0;
  int rasLowRun = 0, rasHighRun = 1000, casLowRun = 0, casHighRun = 1000, rasFalls = 0;
  always @(negedge clk) if (rstDone) begin
    if (prevRas && !rasN) begin
      chk(rasHighRun >= RP_CYC, "R8", "precharge cycles", rasHighRun, RP_CYC);
      chk(int'(dramAddr[ROW_W-1:0]) == accRow, "R2", "row at rasN fall",
          int'(dramAddr[ROW_W-1:0]), accRow);
      rasFalls++; firstCas = 1;
    end
    if (prevCas && !casN) begin
      if (firstCas) chk(rasLowRun >= RCD_CYC, "R9", "row-to-column cycles", rasLowRun, RCD_CYC);
      else          chk(casHighRun >= CP_CYC, "R9", "casN high cycles", casHighRun, CP_CYC);
      firstCas = 0;
      chk(int'(dramAddr[COL_W-1:0]) == accCol, "R2", "column at casN fall",
          int'(dramAddr[COL_W-1:0]), accCol);
      if (!weN) chk(!prevWe, "R4", "weN low before casN fall", int'(prevWe), 0);
    end
    if (!prevCas && casN) chk(casLowRun >= CAS_CYC, "R9", "casN low cycles", casLowRun, CAS_CYC);
    chk(!(!casN && rasN), "R9", "casN low with rasN high", int'(casN), 1);
    if (!casN && !prevCas) chk(weN == prevWe, "R4", "weN moved under casN", int'(weN), int'(prevWe));
    if (!casN && !weN) chk(oeN, "R4", "oeN during write", int'(oeN), 1);
    if (!rasN) chk(rasLowRun + 1 <= RASMAX_CYC, "R7", "rasN low run", rasLowRun + 1, RASMAX_CYC);
    if (refAck) chk(rasN && casN, "R10", "strobes idle at refAck", int'({rasN, casN}), 3);
    if (hostRvalid) begin
      if (expQ.size() == 0) chk(0, "R3", "rvalid with no read pending", int'(hostRdata), -1);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        chk(hostRdata === e, "R3", "read data", int'(hostRdata), int'(e));
      end
    end
    rasLowRun  = rasN ? 0 : rasLowRun + 1;
    rasHighRun = rasN ? rasHighRun + 1 : 0;
    casLowRun  = casN ? 0 : casLowRun + 1;
    casHighRun = casN ? casHighRun + 1 : 0;
    prevRas = rasN; prevCas = casN; prevWe = weN;
  end

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      chk(0, "R3", "watchdog expired", cycles, 50000);
      finishRun();
    end
  end

  initial begin
    int f0;
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(rasN && casN && weN && oeN, "R1", "strobes after reset",
        int'({rasN, casN, weN, oeN}), 15);
    chk(!dqOe && !hostRvalid, "R1", "drive/rvalid after reset", int'({dqOe, hostRvalid}), 0);
    chk(hostReady, "R1", "ready after reset", int'(hostReady), 1);
    rstDone = 1;

    // R3 write then read back, and an unwritten location
    access(1, 5, 10, 8'h3C);
    access(0, 5, 10, 8'h00);
    access(0, 100, 3, 8'h00);
    repeat (30) @(negedge clk);

    // R5 page burst: writes then reads in one row
    f0 = rasFalls;
    for (int i = 0; i < 4; i++) access(1, 7, i, 8'(8'h40 + i));
    for (int i = 0; i < 4; i++) access(0, 7, i, 8'h00);
    repeat (30) @(negedge clk);
    chk(rasFalls - f0 == 1, "R5", "activations for one-row burst", rasFalls - f0, 1);

    // R6 row misses
    f0 = rasFalls;
    access(0, 7, 1, 8'h00);
    access(0, 9, 1, 8'h00);
    access(0, 7, 2, 8'h00);
    repeat (30) @(negedge clk);
    chk(rasFalls - f0 == 3, "R6", "activations for alternating rows", rasFalls - f0, 3);

    // R7 long burst is split: 11 accesses fit in one activation
    f0 = rasFalls;
    for (int i = 0; i < 20; i++) access(0, 7, i, 8'h00);
    repeat (30) @(negedge clk);
    chk(rasFalls - f0 == 2, "R7", "activations for 20-access burst", rasFalls - f0, 2);

    // R4 mixed read and write in one row
    for (int i = 0; i < 6; i++) begin
      access(1, 3, 200 + i, 8'(8'hC0 ^ i));
      access(0, 3, 200 + i, 8'h00);
    end
    repeat (30) @(negedge clk);

    // R10 refresh request closes the row and blocks the host
    access(0, 2, 0, 8'h00);
    @(negedge clk);
    refReq = 1; hostReq = 1; hostWe = 0;
    hostAddr = {12'd2, 9'd1};
    for (int i = 0; i < 40 && !refAck; i++) @(negedge clk);
    chk(refAck, "R10", "refAck seen", int'(refAck), 1);
    f0 = rasFalls;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!hostReady, "R10", "ready while refresh pending", int'(hostReady), 0);
    end
    chk(rasFalls == f0, "R10", "no activation during refresh", rasFalls - f0, 0);
    refReq = 0;
    hostReq = 0;
    access(0, 2, 1, 8'h00);
    repeat (30) @(negedge clk);
    chk(rasFalls - f0 == 1, "R10", "row reopened after refresh", rasFalls - f0, 1);

    chk(expQ.size() == 0, "R3", "reads left without rvalid", expQ.size(), 0);
    finishRun();
  end

endmodule